// File: doc/BRIEF.md
# Switchable-Sign Multiply-Add Unit

This block forms `z = c ± a·b` from three narrow operands and returns a wider result. One control bit decides whether all three operands are read as unsigned numbers or as two's-complement numbers. A second control bit decides whether the product is added to `c` or subtracted from it. It is meant to be dropped into a datapath wherever a small multiply-accumulate step has to serve both number formats without duplicating hardware.

Both signednesses share a single signed multiply-add that is one bit wider than the operands. Each operand is widened by one bit. The new top bit is the operand's MSB when two's-complement mode is on, and zero when it is off. For subtraction, the widened `a` operand is negated arithmetically before the multiply. The product itself is never negated. The sum is truncated to the output width. By default the result passes through one output register with a synchronous active-high reset.

Top module: `smac_unit`

## Requirements
- R1: With `twos_cmp`=0 and `sub_prod`=0, `z` equals (a·b + c) mod 2^16, where all three operands are read as unsigned.
- R2: With `twos_cmp`=1 and `sub_prod`=0, `z` equals the low 16 bits of the two's-complement value a·b + c, where each 8-bit operand has bit 7 as its sign bit.
- R3: With `twos_cmp`=0 and `sub_prod`=1, `z` equals (c − a·b) mod 2^16, with unsigned operands.
- R4: With `twos_cmp`=1 and `sub_prod`=1, `z` equals the low 16 bits of c − a·b, with two's-complement operands.
- R5: Bit 7 of an operand is treated as a sign bit only when `twos_cmp`=1. For example, a=0, c=8'h80 gives `z`=16'h0080 when `twos_cmp`=0 and `z`=16'hFF80 when `twos_cmp`=1.
- R6: In two's-complement subtraction, a=8'h80 (−128) is negated to +128 without wrapping. For example, b=1 and c=0 give `z`=16'h0080.
- R7: With the output register enabled (the default), `z` takes the result of the inputs present at a rising clock edge at that edge, and holds it until the next edge.
- R8: When `rst` is 1 at a rising edge, `z` is 16'h0000 after that edge, whatever the inputs are.
- R9: When a=0, `z` equals `c` extended to 16 bits, by zeros or by its sign according to `twos_cmp`, regardless of `sub_prod`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 8 | Multiplicand, negated first when subtracting |
| op_b | input | 8 | Multiplier |
| op_c | input | 8 | Addend |
| twos_cmp | input | 1 | 1: operands are two's-complement; 0: operands are unsigned |
| sub_prod | input | 1 | 1: subtract the product from c; 0: add it |
| z | output | 16 | Truncated result, registered by default |

## Verification
The operands are driven with the boundary values 0, 127, 128 and 255 in every combination, under all four settings of the two mode bits. This separates zero-extension from sign-extension exactly where bit 7 flips. It also exposes a subtraction that negates the wrong operand or wraps −128. Random vectors under each mode catch carry and truncation errors in the middle of the range. Two targeted patterns complete the checks. The pair a=0, c=0x80 isolates how `c` is extended. A mid-run reset and a before/after-edge sample confirm that the register clears `z` and updates it only at the edge.

// File: rtl/smac_pkg.sv
package smac_pkg;
  // Mode controls shared by the datapath sub-blocks.
  typedef struct packed {
    logic twos;  // operands read as two's-complement
    logic sub;   // subtract the product instead of adding
  } smac_mode_t;

  localparam int unsigned N_OPS = 3;  // a, b, c
  localparam int unsigned IDX_A = 0;
  localparam int unsigned IDX_B = 1;
  localparam int unsigned IDX_C = 2;
endpackage

// File: rtl/smac_extend.sv
// Widens one operand by a single bit: sign copy in two's-complement mode,
// zero otherwise.
module smac_extend #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]  val_i,
  input  logic          twos_i,
  output logic signed [W:0] ext_o
);
  assign ext_o = $signed({twos_i & val_i[W-1], val_i});
endmodule

// File: rtl/smac_negate.sv
// Conditional arithmetic negation of the widened multiplicand. The extra
// bit keeps -(-2^(W-1)) and -(2^W-1) representable.
module smac_negate #(
  parameter int unsigned W = 8
) (
  input  logic signed [W:0] val_i,
  input  logic              neg_i,
  output logic signed [W:0] res_o
);
  assign res_o = neg_i ? -val_i : val_i;
endmodule

// File: rtl/smac_core.sv
// Single signed multiply-add on the widened operands, truncated to OW bits.
module smac_core #(
  parameter int unsigned W  = 8,
  parameter int unsigned OW = 16
) (
  input  logic signed [W:0] a_i,
  input  logic signed [W:0] b_i,
  input  logic signed [W:0] c_i,
  output logic [OW-1:0]     z_o
);
  localparam int unsigned PW = 2 * (W + 1);
  localparam int unsigned SW = ((PW > OW) ? PW : OW) + 1;

  logic signed [SW-1:0] a_w, b_w, c_w, acc;

  assign a_w = $signed({{(SW-W-1){a_i[W]}}, a_i});
  assign b_w = $signed({{(SW-W-1){b_i[W]}}, b_i});
  assign c_w = $signed({{(SW-W-1){c_i[W]}}, c_i});
  assign acc = a_w * b_w + c_w;
  assign z_o = acc[OW-1:0];
endmodule

// File: rtl/smac_unit.sv
module smac_unit #(
  parameter int unsigned W       = 8,
  parameter int unsigned OW      = 16,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [W-1:0]  op_c,
  input  logic          twos_cmp,
  input  logic          sub_prod,
  output logic [OW-1:0] z
);
  import smac_pkg::*;

  localparam int unsigned XW = OW - W;

  smac_mode_t                         mode;
  logic [N_OPS-1:0][W-1:0]            ops;
  logic signed [W:0]                  ext [N_OPS];
  logic signed [W:0]                  a_neg;
  logic [OW-1:0]                      z_comb;

  assign mode = '{twos: twos_cmp, sub: sub_prod};
  assign ops[IDX_A] = op_a;
  assign ops[IDX_B] = op_b;
  assign ops[IDX_C] = op_c;

  for (genvar i = 0; i < N_OPS; i++) begin : g_ext
    smac_extend #(.W(W)) ext_i (
      .val_i (ops[i]),
      .twos_i(mode.twos),
      .ext_o (ext[i])
    );
  end

  smac_negate #(.W(W)) neg_i (
    .val_i(ext[IDX_A]),
    .neg_i(mode.sub),
    .res_o(a_neg)
  );

  smac_core #(.W(W), .OW(OW)) core_i (
    .a_i(a_neg),
    .b_i(ext[IDX_B]),
    .c_i(ext[IDX_C]),
    .z_o(z_comb)
  );

  if (OUT_REG) begin : g_reg
    logic [OW-1:0] z_q;
    always_ff @(posedge clk) begin
      if (rst) z_q <= '0;
      else     z_q <= z_comb;
    end
    assign z = z_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (z == '0)); // R8

    AST_UNSIGNED_SUM: assert property (@(posedge clk) disable iff (rst)
      (!twos_cmp && !sub_prod) |=>
        (z == $past({{XW{1'b0}}, op_a} * {{XW{1'b0}}, op_b} + {{XW{1'b0}}, op_c}))); // R1

    AST_UNSIGNED_DIFF_B1: assert property (@(posedge clk) disable iff (rst)
      (!twos_cmp && sub_prod && op_b == W'(1)) |=>
        (z == $past({{XW{1'b0}}, op_c} - {{XW{1'b0}}, op_a}))); // R3

    AST_ZERO_A_PASSES_C: assert property (@(posedge clk) disable iff (rst)
      (op_a == '0) |=>
        (z == $past(twos_cmp ? {{XW{op_c[W-1]}}, op_c} : {{XW{1'b0}}, op_c}))); // R9

    AST_NO_NEG_WRAP: assert property (@(posedge clk) disable iff (rst)
      (twos_cmp && sub_prod && op_a == {1'b1, {(W-1){1'b0}}} &&
       op_b == W'(1) && op_c == '0) |=>
        (z == OW'(1 << (W-1)))); // R6
  end else begin : g_comb
    assign z = z_comb;
  end
endmodule

// File: tb/smac_unit_tb_top.sv
module smac_unit_tb_top;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a = '0, b = '0, c = '0;
  logic       tc = 1'b0, sb = 1'b0;
  logic [15:0] z;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  smac_unit dut_i (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .op_c(c),
    .twos_cmp(tc), .sub_prod(sb), .z(z)
  );

  function automatic logic [15:0] ref_z(logic [7:0] xa, logic [7:0] xb,
                                        logic [7:0] xc, logic t, logic s);
    int va = (t && xa[7]) ? int'(xa) - 256 : int'(xa);
    int vb = (t && xb[7]) ? int'(xb) - 256 : int'(xb);
    int vc = (t && xc[7]) ? int'(xc) - 256 : int'(xc);
    int r  = s ? vc - va * vb : vc + va * vb;
    logic [31:0] rb = r;
    return rb[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: z=%h expected %h", req, act, exp);
    end
  endtask

  // Drive at falling edge, capture at rising edge, sample 1 ns later.
  task automatic apply(logic [7:0] xa, logic [7:0] xb, logic [7:0] xc,
                       logic t, logic s);
    @(negedge clk);
    a = xa; b = xb; c = xc; tc = t; sb = s;
    @(posedge clk);
    #1ns;
  endtask

  task automatic run_vec(string req, logic [7:0] xa, logic [7:0] xb,
                         logic [7:0] xc, logic t, logic s);
    apply(xa, xb, xc, t, s);
    check(req, z, ref_z(xa, xb, xc, t, s));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    a = 8'hFF; b = 8'hFF; c = 8'hFF;
    repeat (2) @(posedge clk);
    #1ns;
    check("R8 reset value", z, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_mode(string req, logic t, logic s);
    logic [7:0] corner [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++)
          run_vec(req, corner[i], corner[j], corner[k], t, s);
    for (int n = 0; n < 200; n++)
      run_vec(req, 8'($urandom), 8'($urandom), 8'($urandom), t, s);
  endtask

  task automatic t_extension;
    run_vec("R5 zero-extend c", 8'h00, 8'h55, 8'h80, 1'b0, 1'b0);
    check("R5 zero-extend c literal", z, 16'h0080);
    run_vec("R5 sign-extend c", 8'h00, 8'h55, 8'h80, 1'b1, 1'b0);
    check("R5 sign-extend c literal", z, 16'hFF80);
    run_vec("R5 unsigned a=255,b=255", 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0);
    check("R5 unsigned square literal", z, 16'hFE01);
    run_vec("R5 signed a=-1,b=-1", 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0);
    check("R5 signed square literal", z, 16'h0001);
  endtask

  task automatic t_min_neg;
    run_vec("R6 negate -128", 8'h80, 8'h01, 8'h00, 1'b1, 1'b1);
    check("R6 negate -128 literal", z, 16'h0080);
    run_vec("R6 -(-128*-128)", 8'h80, 8'h80, 8'h00, 1'b1, 1'b1);
    check("R6 -(-128*-128) literal", z, 16'hC000);
  endtask

  task automatic t_zero_a;
    run_vec("R9 a=0 sub unsigned", 8'h00, 8'hC3, 8'h9A, 1'b0, 1'b1);
    check("R9 a=0 sub unsigned literal", z, 16'h009A);
    run_vec("R9 a=0 sub signed", 8'h00, 8'hC3, 8'h9A, 1'b1, 1'b1);
    check("R9 a=0 sub signed literal", z, 16'hFF9A);
  endtask

  task automatic t_latency;
    logic [15:0] prev;
    run_vec("R7 first", 8'h12, 8'h34, 8'h56, 1'b0, 1'b0);
    prev = z;
    @(negedge clk);
    a = 8'hAB; b = 8'hCD; c = 8'hEF; tc = 1'b1; sb = 1'b1;
    #1ns;
    check("R7 held before edge", z, prev);
    @(posedge clk);
    #1ns;
    check("R7 updated at edge", z, ref_z(8'hAB, 8'hCD, 8'hEF, 1'b1, 1'b1));
  endtask

  task automatic t_mid_reset;
    run_vec("R8 pre-reset", 8'h7F, 8'h7F, 8'h7F, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1ns;
    check("R8 mid-run reset", z, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1ns;
    check("R8 resume after reset", z, ref_z(8'h7F, 8'h7F, 8'h7F, 1'b0, 1'b0));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_mode("R1 unsigned add", 1'b0, 1'b0);
    t_mode("R2 signed add", 1'b1, 1'b0);
    t_mode("R3 unsigned sub", 1'b0, 1'b1);
    t_mode("R4 signed sub", 1'b1, 1'b1);
    t_extension();
    t_min_neg();
    t_zero_a();
    t_latency();
    t_mid_reset();
    finish_run();
  end
endmodule